// File: doc/BRIEF.md
# Serial Clock Pulse Count Write Guard

This block guards a serial memory's modifying instructions against stray clock edges. It counts the serial clock pulses that begin with the start bit and continue up to the falling edge of chip select. When chip select falls it compares that count with the frame length that the decoded instruction class and the selected organisation require. A modifying instruction is permitted only when the count matches exactly. If a glitch adds even one pulse, the address and data bits would be shifted by one position, so the command is rejected and memory is left untouched.

The surrounding serial front end supplies single-cycle strobes in the system clock domain: a serial clock rising edge, start bit detected (raised together with the rising edge of the start bit), and chip select falling. It also holds the decoded instruction class and the organisation select steady until chip select falls. One cycle after the chip select strobe, the guard answers with a single-cycle permit pulse or a single-cycle reject pulse. A parameter removes the comparison, which models a part that has no guard.

Top module: `ckpg_guard`

## Requirements
- R1: After reset `permit_o` and `reject_o` are low.
- R2: Class write (`cls_i`=1) with `org16_i`=0 is permitted when exactly 18 pulses are counted, with the start pulse included. The `permit_o` pulse is high in the cycle after `cs_fall_i`.
- R3: Class write with `org16_i`=1 is permitted when exactly 25 pulses are counted.
- R4: Class erase (`cls_i`=2) and class erase-all (`cls_i`=3) are permitted at 10 pulses when `org16_i`=0 and at 9 pulses when `org16_i`=1. Any other count is rejected.
- R5: Class write-all (`cls_i`=4) uses the same totals as write: 18 pulses for x8 and 25 pulses for x16.
- R6: For a modifying class, a count that differs from the expected total by one pulse in either direction gives a `reject_o` pulse and no `permit_o`.
- R7: Class 0 (read, enable, disable, idle) never produces `permit_o` or `reject_o`.
- R8: The counter saturates one above the longest frame. A long burst, such as 50 pulses on an x8 write, is rejected and does not wrap into a match.
- R9: Serial clock pulses before the start bit are not counted. The count clears at every chip select fall, so a frame that follows an aborted frame is judged on its own pulses.
- R10: `permit_o` and `reject_o` are never high together, and each lasts exactly one cycle.
- R11: With `GUARD_EN`=0, every modifying class that has seen a start bit is permitted whatever its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_rise_i | input | 1 | Strobe for a serial clock rising edge |
| start_i | input | 1 | Start bit detected; asserted with its own `sck_rise_i` |
| cls_i | input | 3 | Instruction class: 0 none, 1 write, 2 erase, 3 erase-all, 4 write-all |
| org16_i | input | 1 | Organisation: 1 selects x16, 0 selects x8 |
| cs_fall_i | input | 1 | Strobe for a chip select falling edge |
| permit_o | output | 1 | Pulse that lets the modifying instruction execute |
| reject_o | output | 1 | Pulse that drops the modifying instruction |

## Verification
Exact-length frames are driven for every modifying class in both organisations. These show that each class and organisation maps to the right total. Frames one pulse short and one pulse long show that the comparison is exact, not a threshold. A 50-pulse burst tells saturation apart from a counter that wraps modulo 32 and lands back on 18. Pulses before the start bit and an aborted short frame followed by a clean frame show that counting is armed by the start bit and cleared by chip select. An unguarded instance driven alongside shows what the check adds.

// File: rtl/ckpg_pkg.sv
package ckpg_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_WRITE = 3'd1,
    CLS_ERASE = 3'd2,
    CLS_ERALL = 3'd3,
    CLS_WRALL = 3'd4
  } cls_e;
endpackage

// File: rtl/ckpg_len_decode.sv
module ckpg_len_decode
  import ckpg_pkg::*;
#(
  parameter int OP_BITS = 2,
  parameter int ADR8    = 7,
  parameter int ADR16   = 6,
  parameter int DAT8    = 8,
  parameter int DAT16   = 16,
  parameter int CNT_W   = 5
) (
  input  logic [2:0]       cls_i,
  input  logic             org16_i,
  output logic             is_mod_o,
  output logic [CNT_W-1:0] exp_len_o
);
  localparam int HDR8  = 1 + OP_BITS + ADR8;
  localparam int HDR16 = 1 + OP_BITS + ADR16;
  localparam int WR8   = HDR8 + DAT8;
  localparam int WR16  = HDR16 + DAT16;

  cls_e cls;
  assign cls = cls_e'(cls_i);

  always_comb begin
    is_mod_o  = 1'b0;
    exp_len_o = '0;
    unique case (cls)
      CLS_WRITE, CLS_WRALL: begin
        is_mod_o  = 1'b1;
        exp_len_o = org16_i ? CNT_W'(WR16) : CNT_W'(WR8);
      end
      CLS_ERASE, CLS_ERALL: begin
        is_mod_o  = 1'b1;
        exp_len_o = org16_i ? CNT_W'(HDR16) : CNT_W'(HDR8);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ckpg_counter.sv
module ckpg_counter #(
  parameter int SAT   = 26,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_rise_i,
  input  logic             start_i,
  input  logic             cs_fall_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_o <= 1'b0;
      cnt_o   <= '0;
    end else if (cs_fall_i) begin
      armed_o <= 1'b0;
      cnt_o   <= '0;
    end else if (start_i && sck_rise_i) begin
      armed_o <= 1'b1;
      cnt_o   <= CNT_W'(1);
    end else if (armed_o && sck_rise_i && cnt_o != CNT_W'(SAT)) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  // R8
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_W'(SAT));
  // R9
  cnt_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (cnt_o == '0 && !armed_o));
  // R9
  no_count_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_o && !start_i) |=> cnt_o == '0);
endmodule

// File: rtl/ckpg_guard.sv
module ckpg_guard
  import ckpg_pkg::*;
#(
  parameter bit GUARD_EN = 1'b1,
  parameter int OP_BITS  = 2,
  parameter int ADR8     = 7,
  parameter int ADR16    = 6,
  parameter int DAT8     = 8,
  parameter int DAT16    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_rise_i,
  input  logic       start_i,
  input  logic [2:0] cls_i,
  input  logic       org16_i,
  input  logic       cs_fall_i,
  output logic       permit_o,
  output logic       reject_o
);
  localparam int WR8   = 1 + OP_BITS + ADR8 + DAT8;
  localparam int WR16  = 1 + OP_BITS + ADR16 + DAT16;
  localparam int MAXL  = (WR8 > WR16) ? WR8 : WR16;
  localparam int SAT   = MAXL + 1;
  localparam int CNT_W = $clog2(SAT + 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] exp_len;
  logic             is_mod;
  logic             cnt_ok;
  logic             ok;

  ckpg_counter #(.SAT(SAT), .CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .sck_rise_i, .start_i, .cs_fall_i,
    .armed_o(armed), .cnt_o(cnt)
  );

  ckpg_len_decode #(
    .OP_BITS(OP_BITS), .ADR8(ADR8), .ADR16(ADR16),
    .DAT8(DAT8), .DAT16(DAT16), .CNT_W(CNT_W)
  ) u_dec (
    .cls_i, .org16_i, .is_mod_o(is_mod), .exp_len_o(exp_len)
  );

  assign cnt_ok = (cnt == exp_len);

  generate
    if (GUARD_EN) begin : g_guard
      assign ok = armed && cnt_ok;
    end else begin : g_bypass
      assign ok = armed || (cnt_ok && 1'b0);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      permit_o <= 1'b0;
      reject_o <= 1'b0;
    end else begin
      permit_o <= cs_fall_i && is_mod && ok;
      reject_o <= cs_fall_i && is_mod && !ok;
    end
  end

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(permit_o && reject_o));
  // R10
  permit_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit_o |-> $past(cs_fall_i));
  // R10
  reject_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> $past(cs_fall_i));
  // R7
  nonmod_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_fall_i && cls_i == 3'd0) |=> !(permit_o || reject_o));
endmodule

// File: tb/ckpg_guard_bench.sv
`timescale 1ns/1ps
module ckpg_guard_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, start = 1'b0, csf = 1'b0, org16 = 1'b0;
  logic [2:0] cls = 3'd0;
  logic perm_g, rej_g, perm_n, rej_n;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ckpg_guard u_ckpg_guard (
    .clk_i(clk), .rst_ni(rst_n), .sck_rise_i(sck), .start_i(start),
    .cls_i(cls), .org16_i(org16), .cs_fall_i(csf),
    .permit_o(perm_g), .reject_o(rej_g)
  );

  ckpg_guard #(.GUARD_EN(1'b0)) u_ckpg_guard_ng (
    .clk_i(clk), .rst_ni(rst_n), .sck_rise_i(sck), .start_i(start),
    .cls_i(cls), .org16_i(org16), .cs_fall_i(csf),
    .permit_o(perm_n), .reject_o(rej_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drives pre unarmed pulses, then n counted pulses (first carries start), then cs fall
  logic [1:0] res_g, res_n;
  task automatic frame(input logic [2:0] c, input logic o, input int pre, input int n);
    @(negedge clk); cls = c; org16 = o;
    for (int i = 0; i < pre; i++) begin
      @(negedge clk); sck = 1'b1;
      @(negedge clk); sck = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sck = 1'b1; start = (i == 0);
      @(negedge clk); sck = 1'b0; start = 1'b0;
    end
    @(negedge clk); csf = 1'b1;
    @(negedge clk); csf = 1'b0;
    res_g = {perm_g, rej_g};
    res_n = {perm_n, rej_n};
    // R10
    chk(!(perm_g && rej_g), "R10 exclusive", int'(res_g), 0);
    @(negedge clk);
    // R10
    chk(!perm_g && !rej_g, "R10 single cycle", int'({perm_g, rej_g}), 0);
    cls = 3'd0;
  endtask

  task automatic expect_g(input bit p, input string req);
    chk(res_g == {p, ~p}, req, int'(res_g), int'({p, ~p}));
  endtask

  task automatic t_reset;
    chk(!perm_g && !rej_g, "R1 reset outputs", int'({perm_g, rej_g}), 0);
  endtask

  task automatic t_write;
    frame(3'd1, 1'b0, 0, 18); expect_g(1'b1, "R2 x8 write 18");
    frame(3'd1, 1'b1, 0, 25); expect_g(1'b1, "R3 x16 write 25");
  endtask

  task automatic t_erase;
    frame(3'd2, 1'b0, 0, 10); expect_g(1'b1, "R4 x8 erase 10");
    frame(3'd2, 1'b1, 0, 9);  expect_g(1'b1, "R4 x16 erase 9");
    frame(3'd3, 1'b0, 0, 10); expect_g(1'b1, "R4 x8 erase-all 10");
    frame(3'd3, 1'b1, 0, 9);  expect_g(1'b1, "R4 x16 erase-all 9");
    frame(3'd2, 1'b0, 0, 9);  expect_g(1'b0, "R4 x8 erase 9 rejected");
  endtask

  task automatic t_wrall;
    frame(3'd4, 1'b0, 0, 18); expect_g(1'b1, "R5 x8 write-all 18");
    frame(3'd4, 1'b1, 0, 25); expect_g(1'b1, "R5 x16 write-all 25");
  endtask

  task automatic t_off_by_one;
    frame(3'd1, 1'b0, 0, 17); expect_g(1'b0, "R6 x8 write 17");
    chk(res_n == 2'b10, "R11 unguarded permits 17", int'(res_n), 2);
    frame(3'd1, 1'b0, 0, 19); expect_g(1'b0, "R6 x8 write 19");
    frame(3'd1, 1'b1, 0, 24); expect_g(1'b0, "R6 x16 write 24");
    frame(3'd1, 1'b1, 0, 26); expect_g(1'b0, "R6 x16 write 26");
    chk(res_n == 2'b10, "R11 unguarded permits 26", int'(res_n), 2);
  endtask

  task automatic t_nonmod;
    frame(3'd0, 1'b0, 0, 18);
    chk(res_g == 2'b00, "R7 class 0 quiet", int'(res_g), 0);
    chk(res_n == 2'b00, "R7 class 0 quiet unguarded", int'(res_n), 0);
  endtask

  task automatic t_sat;
    frame(3'd1, 1'b0, 0, 50); expect_g(1'b0, "R8 burst of 50 rejected");
  endtask

  task automatic t_arm;
    frame(3'd1, 1'b0, 5, 18); expect_g(1'b1, "R9 pre-start pulses ignored");
    frame(3'd1, 1'b0, 0, 10); expect_g(1'b0, "R9 aborted short frame");
    frame(3'd1, 1'b0, 0, 18); expect_g(1'b1, "R9 fresh count after abort");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_write();
    t_erase();
    t_wrall();
    t_off_by_one();
    t_nonmod();
    t_sat();
    t_arm();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule